// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block moves 32-bit words from a transmit queue out over a single-channel SPI master link and gathers the bytes that come back into a receive queue. One programmable burst, whose length is counted in bits, may be shorter than one word or span several words. Each word goes out least-significant byte first. Within a byte the bits go most-significant first, in SPI mode 0. The serial clock is the system clock divided by a fixed parameter.

A transfer is started in one of two ways. In automatic mode every accepted word starts the engine, and so does turning automatic mode on while words are waiting. In manual mode a 0-to-1 write of the exchange bit starts it. The engine keeps the exchange bit itself: the register block writes it through a strobe and reads it back. The engine clears it when a burst ends. In hold mode it sets it again at the start of each new burst. It gives the register block one-cycle pulses for transfer-complete and receive-overflow, which that block keeps as sticky flags.

Words enter on a valid/ready stream. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the transmit queue is full. Received words leave on a valid/ready stream. `rx_data` holds the oldest word, and it stays valid and unchanged until `rx_ready` takes it.

Top module: `spi_burst_engine`

## Requirements
- R1: A burst is `cfg_burst_m1 + 1` bits long. A signed bit counter is loaded with this length whenever a word is about to be sent and the counter is at or below zero. The counter drops by 8 for every byte sent, and it carries over between drains.
- R2: A popped word sends ceil(min(counter, 32) / 8) bytes, starting with bits [7:0] and going upward. On `mosi` each byte is sent most-significant bit first.
- R3: The byte received during the k-th byte of a word is placed at bits [8k+7:8k] of the received word. Byte positions that were not sent read as zero.
- R4: If the receive queue is full when a word finishes, `ro_set` pulses for one cycle and that word is dropped. The words already queued are unchanged.
- R5: With `cfg_smc` high and `cfg_master` high, each accepted transmit word starts a drain. A 0-to-1 change of `cfg_smc` while words are waiting also starts one.
- R6: With `cfg_smc` low and `cfg_master` high, a write of 1 to the exchange bit while it reads 0 starts a drain. `xch` shows the written value from the next cycle.
- R7: When the bit counter reaches zero or below after a word, `xch` is cleared. Outside hold mode, `tc_set` pulses and draining stops, and any remaining words stay queued.
- R8: Hold mode is active when `cfg_master` is high, `cfg_smc` is low and `cfg_hold` is high. In hold mode draining continues across bursts, and `xch` is set again when each new burst is loaded.
- R9: A drain that finds the transmit queue empty ends with one `tc_set` pulse.
- R10: With `cfg_master` low, no word is sent and nothing is received, whatever is written.
- R11: `tx_ready` is low only while the transmit queue (depth `FIFO_DEPTH`) is full, and a word offered then is not taken. `rx_valid` and `rx_data` hold while `rx_ready` is low.
- R12: `sclk` idles low. Within a byte it has a period of `2*HALF_DIV` clocks. `mosi` changes on the falling edge and `miso` is sampled on the rising edge. `busy` is high while a drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_m1 | input | BURST_W | Burst length in bits minus one |
| cfg_smc | input | 1 | Automatic start mode |
| cfg_master | input | 1 | Selected channel acts as master |
| cfg_hold | input | 1 | Chip-select hold bit of the selected channel |
| xch_wr | input | 1 | Write strobe for the exchange bit |
| xch_wdata | input | 1 | Value written to the exchange bit |
| xch | output | 1 | Current exchange bit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit queue can accept a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Oldest received word |
| tc_set | output | 1 | One-cycle transfer-complete pulse |
| ro_set | output | 1 | One-cycle receive-overflow pulse |
| busy | output | 1 | Drain in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong bit counter shows up within a word's time as a wrong number of bytes on `mosi`. It also shows up as a `tc_set` or `xch` clear that comes one word early or late. A counter that is off by a few bits can stay hidden until a length that is not a multiple of 8 crosses a word boundary, so the bench sweeps every length from 1 to 64 bits over two-word bursts. A byte-order or byte-placement fault is caught on the first received word, because the bench's serial slave returns a distinct byte for every position. Faults in the receive-full or start-condition logic show up only when the receive queue is full or a particular mode is set, and those cases are driven directly.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int WORD_BY = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_BYTE,
    ST_WAIT,
    ST_STORE
  } seq_state_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic       active;
  logic       tick;
  logic [7:0] sr_out, sr_in;
  logic [2:0] bit_n;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign tick = active;
    end else begin : g_div
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !active)               dcnt <= '0;
        else if (dcnt == DW'(HALF_DIV - 1))  dcnt <= '0;
        else                                 dcnt <= dcnt + 1'b1;
      end
      assign tick = active && (dcnt == DW'(HALF_DIV - 1));
    end
  endgenerate

  assign mosi    = sr_out[7];
  assign rx_byte = sr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      sr_out <= '0;
      sr_in  <= '0;
      bit_n  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sclk   <= 1'b0;
        sr_out <= tx_byte;
        bit_n  <= '0;
      end else if (tick) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          sr_in <= {sr_in[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_n == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sr_out <= {sr_out[6:0], 1'b0};
            bit_n  <= bit_n + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int BURST_W    = 12,
  parameter int FIFO_DEPTH = 4,
  parameter int HALF_DIV   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BURST_W-1:0] cfg_burst_m1,
  input  logic               cfg_smc,
  input  logic               cfg_master,
  input  logic               cfg_hold,
  input  logic               xch_wr,
  input  logic               xch_wdata,
  output logic               xch,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [WORD_W-1:0]  tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [WORD_W-1:0]  rx_data,
  output logic               tc_set,
  output logic               ro_set,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  localparam int CW = BURST_W + 2;

  seq_state_t state;

  logic tx_full, tx_empty, tx_pop, tx_push;
  logic rx_full, rx_empty, rx_push;
  logic [WORD_W-1:0] tx_dout;
  logic sh_start, sh_done;
  logic [7:0] sh_rx;

  logic signed [CW-1:0] cnt, burst_len, eff_cnt;
  logic cnt_spent, multi, start_req;
  logic smc_q, xch_q, pend, tc_q, ro_q;
  logic [WORD_W-1:0] word_sr, rx_acc;
  logic [1:0] byte_idx;
  logic [2:0] bytes_left, nbytes;
  logic [5:0] round_up;

  spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
    .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty)
  );

  spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_acc),
    .pop(rx_valid && rx_ready), .dout(rx_data), .full(rx_full), .empty(rx_empty)
  );

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(word_sr[7:0]),
    .done(sh_done), .rx_byte(sh_rx), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign tx_ready = !tx_full;
  assign tx_push  = tx_valid && !tx_full;
  assign rx_valid = !rx_empty;
  assign xch      = xch_q;
  assign tc_set   = tc_q;
  assign ro_set   = ro_q;
  assign busy     = (state != ST_IDLE);

  assign multi     = cfg_master && !cfg_smc && cfg_hold;
  assign burst_len = $signed({2'b00, cfg_burst_m1} + {{(CW-1){1'b0}}, 1'b1});
  assign cnt_spent = cnt[CW-1] || (cnt == '0);
  assign eff_cnt   = cnt_spent ? burst_len : cnt;
  assign round_up  = {1'b0, eff_cnt[4:0]} + 6'd7;
  assign nbytes    = (eff_cnt[CW-1:5] != '0) ? 3'd4 : round_up[5:3];

  assign start_req = cfg_master && (
                       (cfg_smc && tx_push) ||
                       (cfg_smc && !smc_q && !tx_empty) ||
                       (!cfg_smc && xch_wr && xch_wdata && !xch_q));

  assign tx_pop   = (state == ST_LOAD) && !tx_empty;
  assign sh_start = (state == ST_BYTE);
  assign rx_push  = (state == ST_STORE) && !rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      smc_q      <= 1'b0;
      xch_q      <= 1'b0;
      pend       <= 1'b0;
      tc_q       <= 1'b0;
      ro_q       <= 1'b0;
      word_sr    <= '0;
      rx_acc     <= '0;
      byte_idx   <= '0;
      bytes_left <= '0;
    end else begin
      smc_q <= cfg_smc;
      tc_q  <= 1'b0;
      ro_q  <= 1'b0;
      pend  <= start_req || (pend && state != ST_IDLE);

      if (xch_wr)                                          xch_q <= xch_wdata;
      else if (tx_pop && cnt_spent && multi)               xch_q <= 1'b1;
      else if (state == ST_STORE && cnt_spent)             xch_q <= 1'b0;

      unique case (state)
        ST_IDLE: if (pend) state <= ST_LOAD;
        ST_LOAD: begin
          if (tx_empty) begin
            tc_q  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt        <= eff_cnt;
            word_sr    <= tx_dout;
            rx_acc     <= '0;
            byte_idx   <= '0;
            bytes_left <= nbytes;
            state      <= ST_BYTE;
          end
        end
        ST_BYTE: state <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          rx_acc[8*byte_idx +: 8] <= sh_rx;
          word_sr    <= {8'h00, word_sr[WORD_W-1:8]};
          cnt        <= cnt - CW'(8);
          byte_idx   <= byte_idx + 1'b1;
          bytes_left <= bytes_left - 1'b1;
          state      <= (bytes_left == 3'd1) ? ST_STORE : ST_BYTE;
        end
        ST_STORE: begin
          ro_q <= rx_full;
          if (cnt_spent && !multi) begin
            tc_q  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_smc,
  input logic cfg_master,
  input logic cfg_hold,
  input logic xch_wr,
  input logic xch,
  input logic rx_valid,
  input logic rx_ready,
  input logic [31:0] rx_data,
  input logic tc_set,
  input logic ro_set,
  input logic busy,
  input logic sclk
);
  a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r9_tc_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    tc_set |-> !busy);

  a_r4_overflow_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ro_set |-> rx_valid);

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  a_r8_xch_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xch) |-> $past(xch_wr) || $past(cfg_master && !cfg_smc && cfg_hold && busy));

  a_r7_xch_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch) |-> $past(xch_wr) || $past(busy));
endmodule

bind spi_burst_engine spi_burst_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_smc(cfg_smc), .cfg_master(cfg_master),
  .cfg_hold(cfg_hold), .xch_wr(xch_wr), .xch(xch), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .tc_set(tc_set), .ro_set(ro_set),
  .busy(busy), .sclk(sclk)
);

// File: tb/spi_burst_engine_test.sv
module spi_burst_engine_test;
  localparam int BW    = 12;
  localparam int DEPTH = 4;
  localparam int HALF  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [BW-1:0] cfg_burst_m1 = '0;
  logic cfg_smc = 0, cfg_master = 0, cfg_hold = 0;
  logic xch_wr = 0, xch_wdata = 0, xch;
  logic tx_valid = 0, tx_ready;
  logic [31:0] tx_data = '0;
  logic rx_valid, rx_ready = 0;
  logic [31:0] rx_data;
  logic tc_set, ro_set, busy, sclk, mosi, miso;

  spi_burst_engine #(.BURST_W(BW), .FIFO_DEPTH(DEPTH), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_m1(cfg_burst_m1), .cfg_smc(cfg_smc),
    .cfg_master(cfg_master), .cfg_hold(cfg_hold), .xch_wr(xch_wr),
    .xch_wdata(xch_wdata), .xch(xch), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tc_set(tc_set), .ro_set(ro_set), .busy(busy), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  int tests = 0, fails = 0;

  function automatic logic [7:0] resp(input int n);
    return 8'(n * 37 + 3);
  endfunction

  // serial slave: returns resp(n) for the n-th byte, logs what it receives
  int s_idx = 0, s_n = 0;
  logic [7:0] s_in = '0, s_out;
  logic [7:0] mosi_log[$];
  always_comb s_out = resp(s_n);
  assign miso = s_out[3'(7 - s_idx)];
  always @(posedge sclk) s_in = {s_in[6:0], mosi};
  always @(negedge sclk) begin
    if (s_idx == 7) begin
      mosi_log.push_back(s_in);
      s_idx = 0;
      s_n++;
    end else s_idx++;
  end

  int cyc = 0, last_rise = -1, min_gap = 1000, max_gap = 0;
  always @(posedge clk) cyc++;
  always @(posedge sclk) begin
    if (s_idx != 0 && last_rise >= 0) begin
      if (cyc - last_rise < min_gap) min_gap = cyc - last_rise;
      if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
    end
    last_rise = cyc;
  end

  int tc_seen = 0, ro_seen = 0, rises_seen = 0;
  logic xch_prev = 0, busy_seen = 0;
  always @(negedge clk) begin
    if (tc_set) tc_seen++;
    if (ro_set) ro_seen++;
    if (xch && !xch_prev) rises_seen++;
    xch_prev = xch;
    if (busy) busy_seen = 1;
  end

  // reference model state
  logic [31:0] q_tx[$];
  logic [7:0]  exp_mosi[$];
  logic [31:0] exp_rx[$];
  int mcnt = 0, rn = 0, rx_cnt = 0, cur_len = 1;
  int tc_exp = 0, ro_exp = 0, rises_exp = 0;
  bit mx = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_drain(input bit multi);
    while (1) begin
      logic [31:0] w, acc;
      int tb, k;
      if (q_tx.size() == 0) begin tc_exp++; break; end
      if (mcnt <= 0) begin
        mcnt = cur_len;
        if (multi && !mx) rises_exp++;
        if (multi) mx = 1;
      end
      w = q_tx.pop_front();
      tb = (mcnt > 32) ? 32 : mcnt;
      acc = '0;
      k = 0;
      while (tb > 0) begin
        exp_mosi.push_back(w[8*k +: 8]);
        acc[8*k +: 8] = resp(rn);
        rn++; tb -= 8; mcnt -= 8; k++;
      end
      if (rx_cnt == DEPTH) ro_exp++;
      else begin exp_rx.push_back(acc); rx_cnt++; end
      if (mcnt <= 0) begin
        mx = 0;
        if (!multi) begin tc_exp++; break; end
      end
    end
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w, output bit took);
    @(negedge clk);
    tx_valid = 1; tx_data = w;
    took = tx_ready;
    @(negedge clk);
    tx_valid = 0;
    if (took) q_tx.push_back(w);
  endtask

  task automatic push_w(input logic [31:0] w);
    bit t;
    push(w, t);
  endtask

  task automatic write_xch(input bit v);
    @(negedge clk);
    xch_wr = 1; xch_wdata = v;
    @(negedge clk);
    xch_wr = 0;
    if (v && !mx) rises_exp++;
    mx = v;
  endtask

  task automatic smc_kick();
    @(negedge clk); cfg_smc = 0;
    repeat (2) @(negedge clk);
    cfg_smc = 1;
    model_drain(0);
    wait_idle();
  endtask

  task automatic check_mosi(input string req);
    chk(req, "byte count on mosi", mosi_log.size(), exp_mosi.size());
    while (mosi_log.size() > 0 && exp_mosi.size() > 0)
      chk(req, "mosi byte", mosi_log.pop_front(), exp_mosi.pop_front());
    mosi_log.delete(); exp_mosi.delete();
  endtask

  task automatic check_flags(input string req);
    chk(req, "tc pulses", tc_seen, tc_exp);
    chk(req, "ro pulses", ro_seen, ro_exp);
    chk(req, "xch rises", rises_seen, rises_exp);
    chk(req, "xch level", xch, mx);
  endtask

  task automatic read_rx(input string req);
    while (exp_rx.size() > 0) begin
      logic [31:0] d;
      int guard;
      guard = 0;
      @(negedge clk);
      while (!rx_valid && guard < 50) begin @(negedge clk); guard++; end
      chk(req, "rx_valid", rx_valid, 1);
      d = rx_data;
      rx_ready = 1;
      @(negedge clk);
      rx_ready = 0;
      chk(req, "rx word", d, exp_rx.pop_front());
      rx_cnt--;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit took;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R11", "tx_ready after reset", tx_ready, 1);
    chk("R11", "rx_valid after reset", rx_valid, 0);
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "sclk after reset", sclk, 0);
    chk("R6", "xch after reset", xch, 0);

    // R5 automatic start, one full 32-bit burst, byte order R2/R3
    cfg_master = 1; cfg_smc = 1; cfg_burst_m1 = 12'd31; cur_len = 32;
    repeat (2) @(negedge clk);
    push_w(32'h4433_2211);
    model_drain(0);
    wait_idle();
    check_mosi("R5_R2");
    check_flags("R7");
    read_rx("R3");

    // R1 sweep of every length 1..64 bits over two-word bursts
    for (int L = 1; L <= 64; L++) begin
      @(negedge clk); cfg_smc = 0;
      cfg_burst_m1 = BW'(L - 1); cur_len = L;
      push_w(32'(32'h9E37_79B9 * L));
      push_w(32'(~(32'h7F4A_7C15 * L)));
      while (q_tx.size() > 0) smc_kick();
      check_mosi("R1");
      check_flags("R9");
      read_rx("R3");
    end

    // R6 manual start through the exchange bit
    @(negedge clk); cfg_smc = 0; cfg_hold = 0;
    cfg_burst_m1 = 12'd31; cur_len = 32;
    push_w(32'hCAFE_0123);
    push_w(32'h0BAD_F00D);
    while (q_tx.size() > 0) begin
      if (mx) write_xch(0);
      write_xch(1);
      chk("R6", "xch after write", xch, 1);
      model_drain(0);
      wait_idle();
      check_flags("R7");
    end
    check_mosi("R6");
    read_rx("R3");

    // R8 hold mode: several 16-bit bursts in one drain
    cfg_hold = 1; cfg_burst_m1 = 12'd15; cur_len = 16;
    push_w(32'h1357_9BDF);
    push_w(32'h2468_ACE0);
    push_w(32'h0F1E_2D3C);
    if (mx) write_xch(0);
    write_xch(1);
    model_drain(1);
    wait_idle();
    check_mosi("R8");
    check_flags("R8");
    read_rx("R8");
    @(negedge clk); cfg_hold = 0;

    // R10 no transfer when not master
    cfg_master = 0; cfg_smc = 1; busy_seen = 0;
    push_w(32'h5555_AAAA);
    repeat (60) @(negedge clk);
    chk("R10", "busy seen", busy_seen, 0);
    chk("R10", "bytes on mosi", mosi_log.size(), 0);
    chk("R10", "rx_valid", rx_valid, 0);
    cfg_master = 1;
    smc_kick();
    check_mosi("R10");
    read_rx("R10");

    // R11 transmit back-pressure, R4 receive overflow
    cfg_master = 0; cfg_burst_m1 = 12'd7; cur_len = 8;
    for (int i = 0; i < DEPTH; i++) push_w(32'hA0 + 32'(i));
    chk("R11", "tx_ready when full", tx_ready, 0);
    push(32'hDEAD_BEEF, took);
    chk("R11", "word taken when full", took, 0);
    cfg_master = 1;
    for (int i = 0; i < DEPTH; i++) smc_kick();
    chk("R11", "tx_ready after drain", tx_ready, 1);
    push_w(32'h0000_00EE);
    model_drain(0);
    wait_idle();
    check_flags("R4");
    check_mosi("R4");
    begin
      logic [31:0] h;
      h = rx_data;
      repeat (3) @(negedge clk);
      chk("R11", "rx_data held", rx_data, h);
      chk("R11", "rx_valid held", rx_valid, 1);
    end
    read_rx("R4");
    chk("R4", "rx empty after reads", rx_valid, 0);

    // R12 serial clock period inside a byte
    chk("R12", "min sclk period", min_gap, 2 * HALF);
    chk("R12", "max sclk period", max_gap, 2 * HALF);
    chk("R12", "sclk idle", sclk, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule